// File: doc/BRIEF.md
# Tagged Receive FIFO with Command Parking

This block buffers bytes sent by an external host toward an internal consumer, which may be the processor or a DMA engine. Each byte carries one tag bit saying whether it is ordinary data or an in-band command. Data bytes leave through a data read port. When a command byte reaches the front of the queue, the queue stops advancing. The command is copied into a separate holding register, and it stays there until the consumer reads that register.

The data port never stalls. If nothing can be read, either because the queue is empty or because a command is parked at the front, the port returns all ones and removes nothing. The block raises a demand request toward the DMA engine whenever readable data sits at the front. It also raises a service interrupt toward the processor when data has arrived. That interrupt is masked while a DMA channel is assigned to the queue, and DMA reads clear the flag behind it, so traffic serviced by DMA never interrupts the processor.

Top module: `tagged_rx_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `dmaReq`=0, `cmdPending`=0, `overrun`=0, `svcIrq`=0 and `rdData`=8'hFF.
- R2: Data bytes leave in the order they were written. `full` is 1 exactly when DEPTH (16) entries are stored, and `empty` is 1 exactly when none are stored.
- R3: A host write while `full`=1 is dropped and sets `overrun`. `overrun` then stays at 1 until reset.
- R4: A data-port read while `empty`=1 returns 8'hFF and removes nothing. The next byte written is the next byte read.
- R5: A byte written with `hostWrCmd`=1 is a command. One cycle after it reaches the front, `cmdPending`=1 and `cmdHold` holds its value.
- R6: While a command is at the front, data-port reads (`cpuRdEn` or `dmaRdEn`) return 8'hFF and remove nothing.
- R7: A pulse on `cmdRdEn` while `cmdPending`=1 removes the command and clears `cmdPending`, and the bytes behind it become readable. A pulse on `cmdRdEn` while `cmdPending`=0 has no effect.
- R8: `dmaReq` is 1 exactly when the queue is not empty and the front entry is a data byte.
- R9: An accepted data write sets the service flag. A data-port read that removes a byte clears it. `svcIrq` shows the flag while `dmaAssigned`=0.
- R10: `svcIrq` stays 0 while `dmaAssigned`=1. A byte removed by a DMA read leaves no interrupt behind after `dmaAssigned` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe, one byte per cycle |
| hostWrData | input | 8 | Host write byte |
| hostWrCmd | input | 1 | Tag: 1 = command byte, 0 = data byte |
| cpuRdEn | input | 1 | Processor read of the data port |
| dmaRdEn | input | 1 | DMA read of the data port |
| cmdRdEn | input | 1 | Read of the command holding register |
| dmaAssigned | input | 1 | A DMA channel services this queue and is not done |
| rdData | output | 8 | Data port value; 8'hFF when nothing is readable |
| cmdHold | output | 8 | Command holding register |
| cmdPending | output | 1 | A command is parked at the front |
| dmaReq | output | 1 | Demand request toward the DMA engine |
| svcIrq | output | 1 | Service interrupt toward the processor |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entries |
| overrun | output | 1 | Sticky: a host write was dropped |

## Verification
Ordering is tried with a fill to capacity followed by a full drain. This separates a correct wrap of the pointers from an off-by-one in the full and empty status. A data-command-data pattern shows whether the command parks the queue, whether blocked reads leave the byte behind it intact, and whether the command read releases the queue. Reads from an empty queue and stray command reads are each followed by a fresh write, which reveals any consumption that should not have happened. Interrupt patterns alternate processor reads, DMA reads and masked intervals, to tell masking apart from clearing of the flag.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic loadCmd;
  } fifoStrobe_t;
endpackage

// File: rtl/rxfifo_datapath.sv
module rxfifo_datapath
  import rxfifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   strobe,
  input  logic [DW-1:0] wrData,
  input  logic          wrTag,
  output logic [DW-1:0] headData,
  output logic          headTag,
  output logic [DW-1:0] cmdHold,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= {wrTag, wrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdHold <= '0;
    else if (strobe.loadCmd) cmdHold <= headData;
  end

  assign headData = mem[rdPtr][DW-1:0];
  assign headTag  = mem[rdPtr][DW];
  assign full     = (count == FULLCNT);
  assign empty    = (count == '0);

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !full); // R3
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !empty); // R2
  AST_LOAD_ON_CMD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCmd |-> (headTag && !empty && !strobe.pop)); // R5
endmodule

// File: rtl/rxfifo_ctrl.sv
module rxfifo_ctrl
  import rxfifo_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic        hostWrCmd,
  input  logic        cpuRdEn,
  input  logic        dmaRdEn,
  input  logic        cmdRdEn,
  input  logic        dmaAssigned,
  input  logic        headTag,
  input  logic        full,
  input  logic        empty,
  output fifoStrobe_t strobe,
  output logic        dataReadable,
  output logic        cmdPending,
  output logic        dmaReq,
  output logic        svcIrq,
  output logic        overrun
);
  logic dataRead, cmdTake, irqFlag, dataArrive;

  assign dataReadable = !empty && !headTag;
  assign dataRead     = (cpuRdEn || dmaRdEn) && dataReadable;
  assign cmdTake      = cmdRdEn && cmdPending;
  assign dataArrive   = strobe.push && !hostWrCmd;

  always_comb begin
    strobe         = '0;
    strobe.push    = hostWrEn && !full;
    strobe.pop     = dataRead || cmdTake;
    strobe.loadCmd = !empty && headTag && !cmdPending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdPending <= 1'b0;
      overrun    <= 1'b0;
      irqFlag    <= 1'b0;
    end else begin
      if (cmdTake)             cmdPending <= 1'b0;
      else if (strobe.loadCmd) cmdPending <= 1'b1;
      if (hostWrEn && full)    overrun <= 1'b1;
      if (dataArrive)          irqFlag <= 1'b1;
      else if (dataRead)       irqFlag <= 1'b0;
    end
  end

  assign dmaReq = dataReadable;
  assign svcIrq = irqFlag && !dmaAssigned;

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun); // R3
  AST_PEND_AT_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    cmdPending |-> (!empty && headTag)); // R5
  AST_DMA_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (dmaRdEn && dataReadable && !dataArrive) |=> !irqFlag); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    dmaAssigned |-> !svcIrq); // R10
endmodule

// File: rtl/tagged_rx_fifo.sv
module tagged_rx_fifo
  import rxfifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWrEn,
  input  logic [DW-1:0] hostWrData,
  input  logic          hostWrCmd,
  input  logic          cpuRdEn,
  input  logic          dmaRdEn,
  input  logic          cmdRdEn,
  input  logic          dmaAssigned,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] cmdHold,
  output logic          cmdPending,
  output logic          dmaReq,
  output logic          svcIrq,
  output logic          full,
  output logic          empty,
  output logic          overrun
);
  fifoStrobe_t   strobe;
  logic [DW-1:0] headData;
  logic          headTag, dataReadable;

  rxfifo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrCmd(hostWrCmd),
    .cpuRdEn(cpuRdEn), .dmaRdEn(dmaRdEn), .cmdRdEn(cmdRdEn),
    .dmaAssigned(dmaAssigned), .headTag(headTag), .full(full), .empty(empty),
    .strobe(strobe), .dataReadable(dataReadable), .cmdPending(cmdPending),
    .dmaReq(dmaReq), .svcIrq(svcIrq), .overrun(overrun)
  );

  rxfifo_datapath #(.DW(DW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(hostWrData),
    .wrTag(hostWrCmd), .headData(headData), .headTag(headTag),
    .cmdHold(cmdHold), .full(full), .empty(empty)
  );

  assign rdData = dataReadable ? headData : '1;

  AST_FF_ON_PARK: assert property (@(posedge clk) disable iff (!rstN)
    cmdPending |-> (rdData == '1 && !dmaReq)); // R6
  AST_FF_ON_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> (rdData == '1 && !dmaReq)); // R4
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty)); // R2
endmodule

// File: tb/test_tagged_rx_fifo.sv
module test_tagged_rx_fifo;
  logic clk = 0, rstN = 0;
  logic hostWrEn = 0, hostWrCmd = 0, cpuRdEn = 0, dmaRdEn = 0, cmdRdEn = 0, dmaAssigned = 0;
  logic [7:0] hostWrData = 0;
  logic [7:0] rdData, cmdHold;
  logic cmdPending, dmaReq, svcIrq, full, empty, overrun;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  tagged_rx_fifo i_tagged_rx_fifo (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostWrCmd(hostWrCmd), .cpuRdEn(cpuRdEn), .dmaRdEn(dmaRdEn), .cmdRdEn(cmdRdEn),
    .dmaAssigned(dmaAssigned), .rdData(rdData), .cmdHold(cmdHold),
    .cmdPending(cmdPending), .dmaReq(dmaReq), .svcIrq(svcIrq), .full(full),
    .empty(empty), .overrun(overrun)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic c);
    @(negedge clk); hostWrEn = 1; hostWrData = d; hostWrCmd = c;
    @(negedge clk); hostWrEn = 0; hostWrCmd = 0;
  endtask

  task automatic rd(input logic dma, output logic [7:0] v);
    @(negedge clk); v = rdData; if (dma) dmaRdEn = 1; else cpuRdEn = 1;
    @(negedge clk); dmaRdEn = 0; cpuRdEn = 0;
  endtask

  task automatic rdCmd();
    @(negedge clk); cmdRdEn = 1;
    @(negedge clk); cmdRdEn = 0;
  endtask

  task automatic tReset();
    check("R1 empty", empty, 1); check("R1 full", full, 0);
    check("R1 dmaReq", dmaReq, 0); check("R1 cmdPending", cmdPending, 0);
    check("R1 overrun", overrun, 0); check("R1 svcIrq", svcIrq, 0);
    check("R1 rdData", rdData, 8'hFF);
  endtask

  task automatic tOrder();
    logic [7:0] v;
    for (int i = 0; i < 16; i++) begin
      wr(8'h10 + 8'(i), 0);
      check("R8 dmaReq", dmaReq, 1);
      check("R2 full", full, (i == 15));
    end
    for (int i = 0; i < 16; i++) begin
      rd(0, v); check("R2 order", v, 8'h10 + 8'(i));
    end
    check("R2 empty", empty, 1); check("R8 dmaReq idle", dmaReq, 0);
  endtask

  task automatic tOverrun();
    logic [7:0] v;
    for (int i = 0; i < 16; i++) wr(8'h40 + 8'(i), 0);
    check("R3 no overrun yet", overrun, 0);
    wr(8'hEE, 0);
    check("R3 overrun set", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      rd(1, v); check("R3 dropped byte", v, 8'h40 + 8'(i));
    end
    check("R3 empty after drain", empty, 1);
    check("R3 sticky", overrun, 1);
  endtask

  task automatic tEmptyRead();
    logic [7:0] v;
    rd(0, v); check("R4 empty read", v, 8'hFF);
    rd(1, v); check("R4 empty dma read", v, 8'hFF);
    check("R4 still empty", empty, 1);
    wr(8'h5A, 0);
    rd(0, v); check("R4 next byte", v, 8'h5A);
    check("R4 empty again", empty, 1);
  endtask

  task automatic tCommand();
    logic [7:0] v;
    wr(8'h01, 0); wr(8'hC3, 1); wr(8'h02, 0);
    rd(0, v); check("R2 data before cmd", v, 8'h01);
    @(negedge clk);
    check("R5 pending", cmdPending, 1); check("R5 hold", cmdHold, 8'hC3);
    check("R8 no req on cmd", dmaReq, 0);
    rd(0, v); check("R6 cpu blocked", v, 8'hFF);
    rd(1, v); check("R6 dma blocked", v, 8'hFF);
    check("R6 still pending", cmdPending, 1);
    rdCmd();
    check("R7 pending cleared", cmdPending, 0);
    check("R8 req after release", dmaReq, 1);
    rd(0, v); check("R7 byte behind cmd", v, 8'h02);
    wr(8'h44, 0);
    rdCmd();
    check("R7 stray cmd read", empty, 0);
    rd(0, v); check("R7 stray cmd read keeps byte", v, 8'h44);
    check("R7 drained", empty, 1);
  endtask

  task automatic tIrq();
    logic [7:0] v;
    wr(8'h70, 0); check("R9 irq set", svcIrq, 1);
    rd(0, v); check("R9 irq cleared by read", svcIrq, 0);
    dmaAssigned = 1;
    wr(8'h71, 0); check("R10 masked", svcIrq, 0);
    rd(1, v); check("R10 dma data", v, 8'h71);
    dmaAssigned = 0; @(negedge clk);
    check("R10 no irq after dma", svcIrq, 0);
    dmaAssigned = 1;
    wr(8'h72, 0); check("R10 masked again", svcIrq, 0);
    dmaAssigned = 0; @(negedge clk);
    check("R9 unmasked flag", svcIrq, 1);
    rd(0, v); check("R9 data", v, 8'h72);
    check("R9 cleared", svcIrq, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    @(negedge clk);
    tReset();
    tOrder();
    tEmptyRead();
    tCommand();
    tIrq();
    tOverrun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule